// File: doc/BRIEF.md
# Floppy Device-to-Memory DMA Channel

This block is a single DMA channel that moves a byte stream arriving from a floppy controller into system memory. Software sets up the channel through a small byte-wide register port. It programs the low half of an address pointer and a 16-bit byte count, then issues commands through a control/status byte. A reset command points the channel at a fixed window above a shared DMA base address. A run command loads the live pointer and the live count from the programmed values and opens the device input.

While running, every byte the device offers on its valid/ready input is written to memory at the live pointer in the same cycle. The pointer then advances by one and the count drops by one. When the count reaches zero, the channel sets an interrupt flag and closes its input until software issues the next run command. The interrupt output follows the flag gated by an enable bit. Software clears the flag by writing a one to it.

Top module: `fdma_channel`

## Requirements
- R1: After reset the live pointer, the live count and the status byte all read zero, and `irq` and `dev_ready` are low.
- R2: A control write with bit 0 set (reset command) loads the pointer register and the live pointer with `dma_base + 0x15000` and zeroes the live count. It clears the interrupt flag. The status then equals the written value AND 0x4A.
- R3: A control write without bit 0 sets the status to (old status AND 0x81) OR (written value AND 0x4A). Written bits 0, 2, 4 and 5 never reach the status.
- R4: A control write with bit 7 set clears the interrupt flag (status bit 7). Writing 0 to bit 7 leaves the flag unchanged.
- R5: Register selects 2 and 3 write bits 15:8 and 7:0 of the pointer register. Writes to selects 0 and 1 have no effect. Selects 0 to 3 read the live pointer, most significant byte first.
- R6: Selects 4 and 5 write the high and low bytes of the count register and read the high and low bytes of the live count. A control write with bit 1 set (run command) copies the pointer register into the live pointer and the count register into the live count. When bits 0 and 1 are both set, the reset load takes place first.
- R7: `dev_ready` is high while status bit 1 (RUN) is set and the live count is non-zero. For each accepted byte, `mem_we` pulses in the same cycle with `mem_addr` equal to the live pointer and `mem_wdata` equal to `dev_data`. The live pointer then increments by 1 across its full width, and the live count decrements by 1.
- R8: The byte that takes the live count from 1 to 0 sets status bit 7. `irq` equals status bit 7 AND status bit 6 (IE). No further byte is accepted until a run command reloads a non-zero count. A run command with a zero count transfers nothing and sets no flag.
- R9: Status bit 3 (direction) stores the written value and has no effect on transfers, which always go from the device to memory.
- R10: In a cycle that writes the control register, `dev_ready` is low, so no byte is accepted.
- R11: Select 7 reads zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_base | input | 32 | Shared DMA base address |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dev_valid | input | 1 | Device offers a byte |
| dev_data | input | 8 | Device byte |
| dev_ready | output | 1 | Channel accepts the byte this cycle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `dma_base` is stable around a reset command and that every register write lasts exactly one cycle. They also assume that `dev_data` matters only in cycles where `dev_valid` is high. The bench holds the base constant for the whole run and drives every input on the falling edge. Each write is a single-cycle strobe. A near-exhaustive sweep crosses programmed counts 0 to 5 with offered stream lengths 0 to 7. Some of its pointers sit just below a 64 KiB boundary, so that carries into the upper pointer bytes are exercised.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  // register selects
  localparam logic [2:0] SEL_PTR_B3 = 3'd0;
  localparam logic [2:0] SEL_PTR_B2 = 3'd1;
  localparam logic [2:0] SEL_PTR_B1 = 3'd2;
  localparam logic [2:0] SEL_PTR_B0 = 3'd3;
  localparam logic [2:0] SEL_CNT_HI = 3'd4;
  localparam logic [2:0] SEL_CNT_LO = 3'd5;
  localparam logic [2:0] SEL_CTRL   = 3'd6;

  // control / status bit positions
  localparam int B_RST  = 0;
  localparam int B_RUN  = 1;
  localparam int B_DIR  = 3;
  localparam int B_IE   = 6;
  localparam int B_FLAG = 7;

  localparam logic [7:0] M_KEEP     = 8'h81;
  localparam logic [7:0] M_COPY     = 8'h4A;
  localparam logic [7:0] M_RST_KEEP = 8'h48;
endpackage

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] wdata,
  input  logic       done,
  output logic [7:0] stat,
  output logic       rst_cmd,
  output logic       run_cmd
);
  logic [7:0] stat_q, stat_d, base;
  logic       stat_en;

  always_comb begin
    rst_cmd = ctrl_we & wdata[B_RST];
    run_cmd = ctrl_we & wdata[B_RUN];
    base    = rst_cmd ? (stat_q & M_RST_KEEP) : stat_q;
    stat_d  = stat_q;
    stat_en = ctrl_we | done;
    if (ctrl_we) begin
      stat_d = (base & M_KEEP) | (wdata & M_COPY);
      if (wdata[B_FLAG]) stat_d[B_FLAG] = 1'b0;
    end else if (done) begin
      stat_d[B_FLAG] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_q[B_FLAG]);
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[B_FLAG]) |=> !stat_q[B_FLAG]);
  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[B_FLAG] && !wdata[B_RST]) |=> stat_q[B_FLAG] == $past(stat_q[B_FLAG]));
  p_rst_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[B_RST]) |=> !stat_q[B_FLAG]);
endmodule

// File: rtl/fdma_shadow.sv
module fdma_shadow
  import fdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int WR_BYTES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        wdata,
  input  logic              rst_cmd,
  input  logic [ADDR_W-1:0] rst_ptr,
  output logic [ADDR_W-1:0] prog_ptr,
  output logic [CNT_W-1:0]  prog_cnt
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ptr_en, cnt_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = rst_cmd;
    if (rst_cmd) begin
      ptr_d = rst_ptr;
    end else if (reg_we) begin
      for (int k = 0; k < WR_BYTES; k++) begin
        if (reg_sel == 3'(3 - k)) begin
          ptr_d[8*k +: 8] = wdata;
          ptr_en          = 1'b1;
        end
      end
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (reg_we && reg_sel == SEL_CNT_HI) begin
      cnt_d[CNT_W-1 -: 8] = wdata;
      cnt_en              = 1'b1;
    end else if (reg_we && reg_sel == SEL_CNT_LO) begin
      cnt_d[7:0] = wdata;
      cnt_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign prog_ptr = ptr_q;
  assign prog_cnt = cnt_q;

  p_hi_bytes_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_cmd |=> ptr_q[ADDR_W-1:8*WR_BYTES] == $past(ptr_q[ADDR_W-1:8*WR_BYTES]));
endmodule

// File: rtl/fdma_xfer.sv
module fdma_xfer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_cmd,
  input  logic              run_cmd,
  input  logic              ctrl_we,
  input  logic              run_bit,
  input  logic [ADDR_W-1:0] rst_ptr,
  input  logic [ADDR_W-1:0] prog_ptr,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic              dev_valid,
  output logic              dev_ready,
  output logic              beat,
  output logic              done,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en;

  always_comb begin
    dev_ready = run_bit & (cnt_q != '0) & ~ctrl_we;
    beat      = dev_ready & dev_valid;
    done      = beat & (cnt_q == CNT_W'(1));
    ptr_d     = ptr_q;
    cnt_d     = cnt_q;
    en        = rst_cmd | run_cmd | beat;
    if (run_cmd) begin
      ptr_d = rst_cmd ? rst_ptr : prog_ptr;
      cnt_d = prog_cnt;
    end else if (rst_cmd) begin
      ptr_d = rst_ptr;
      cnt_d = '0;
    end else if (beat) begin
      ptr_d = ptr_q + ADDR_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr = ptr_q;
  assign cnt = cnt_q;

  p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)) && (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_zero_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !dev_ready);
  p_run_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cmd |=> cnt_q == $past(prog_cnt));
  p_rst_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmd && !run_cmd) |=> cnt_q == '0);
  p_ctrl_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |-> !beat);
endmodule

// File: rtl/fdma_channel.sv
module fdma_channel
  import fdma_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 16,
  parameter int          WR_BYTES = 2,
  parameter logic [31:0] RST_OFFS = 32'h0001_5000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dma_base,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dev_valid,
  input  logic [7:0]        dev_data,
  output logic              dev_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(RST_OFFS);

  logic [7:0]        stat;
  logic              ctrl_we, rst_cmd, run_cmd, beat, done;
  logic [ADDR_W-1:0] rst_ptr, prog_ptr, live_ptr;
  logic [CNT_W-1:0]  prog_cnt, live_cnt;

  assign ctrl_we = reg_we & (reg_sel == SEL_CTRL);
  assign rst_ptr = dma_base + OFFS;

  fdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wdata(reg_wdata),
    .done(done), .stat(stat), .rst_cmd(rst_cmd), .run_cmd(run_cmd)
  );

  fdma_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WR_BYTES(WR_BYTES)) u_shadow (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .wdata(reg_wdata), .rst_cmd(rst_cmd), .rst_ptr(rst_ptr),
    .prog_ptr(prog_ptr), .prog_cnt(prog_cnt)
  );

  fdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd), .run_cmd(run_cmd),
    .ctrl_we(ctrl_we), .run_bit(stat[B_RUN]), .rst_ptr(rst_ptr),
    .prog_ptr(prog_ptr), .prog_cnt(prog_cnt), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .beat(beat), .done(done),
    .ptr(live_ptr), .cnt(live_cnt)
  );

  always_comb begin
    case (reg_sel)
      SEL_PTR_B3: reg_rdata = live_ptr[ADDR_W-1 -: 8];
      SEL_PTR_B2: reg_rdata = live_ptr[ADDR_W-9 -: 8];
      SEL_PTR_B1: reg_rdata = live_ptr[15:8];
      SEL_PTR_B0: reg_rdata = live_ptr[7:0];
      SEL_CNT_HI: reg_rdata = live_cnt[CNT_W-1 -: 8];
      SEL_CNT_LO: reg_rdata = live_cnt[7:0];
      SEL_CTRL:   reg_rdata = stat;
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign mem_we    = beat;
  assign mem_addr  = live_ptr;
  assign mem_wdata = dev_data;
  assign irq       = stat[B_FLAG] & stat[B_IE];

  p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done) || $past(ctrl_we));
endmodule

// File: tb/fdma_channel_bench.sv
module fdma_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dma_base = 32'h1234_0000;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        dev_valid = 1'b0;
  logic [7:0]  dev_data = 8'h00;
  logic        dev_ready, mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  localparam logic [31:0] RSTP = 32'h1235_5000;

  always #2 clk = ~clk;

  fdma_channel u_fdma_channel (
    .clk(clk), .rst_n(rst_n), .dma_base(dma_base), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_ptr(output logic [31:0] p);
    logic [7:0] b3, b2, b1, b0;
    rd(3'd0, b3); rd(3'd1, b2); rd(3'd2, b1); rd(3'd3, b0);
    p = {b3, b2, b1, b0};
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] h, l;
    rd(3'd4, h); rd(3'd5, l);
    c = {h, l};
  endtask

  task automatic run_case(input int n, input int m, input logic [15:0] plo,
                          input logic ie, input logic dir);
    logic [31:0] p0, p;
    logic [15:0] c;
    logic [7:0]  s, ctl;
    logic        flag;
    int          acc;
    wr(3'd6, 8'h01);
    wr(3'd2, plo[15:8]);
    wr(3'd3, plo[7:0]);
    wr(3'd4, 8'(n >> 8));
    wr(3'd5, 8'(n));
    ctl = 8'h82 | (ie ? 8'h40 : 8'h00) | (dir ? 8'h08 : 8'h00);
    wr(3'd6, ctl);
    p0 = {RSTP[31:16], plo};
    rd_ptr(p); check("R6 run loads pointer", p, p0);
    rd_cnt(c); check("R6 run loads count", 32'(c), 32'(n));
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      dev_valid = 1'b1;
      dev_data  = 8'(i * 7 + n);
      #1;
      check("R7/R8 ready", 32'(dev_ready), 32'(i < n));
      check("R7 mem_we", 32'(mem_we), 32'(i < n));
      if (i < n) begin
        check("R7 mem_addr", mem_addr, p0 + 32'(i));
        check("R7 mem_wdata", 32'(mem_wdata), 32'(8'(i * 7 + n)));
      end
    end
    @(negedge clk);
    dev_valid = 1'b0;
    acc  = (m < n) ? m : n;
    flag = (n > 0) && (m >= n);
    rd_ptr(p); check("R7 final pointer", p, p0 + 32'(acc));
    rd_cnt(c); check("R7 final count", 32'(c), 32'(n - acc));
    rd(3'd6, s);
    check("R8/R9 status", 32'(s), 32'({flag, ie, 2'b00, dir, 3'b010}));
    check("R8 irq", 32'(irq), 32'(flag & ie));
  endtask

  initial begin : watchdog
    #600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] p;
    logic [15:0] c;
    logic [7:0]  s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_ptr(p); check("R1 pointer", p, 32'h0);
    rd_cnt(c); check("R1 count", 32'(c), 32'h0);
    rd(3'd6, s); check("R1 status", 32'(s), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 ready", 32'(dev_ready), 32'h0);

    // R7 R8 R9 sweep: count 0..5 against offered length 0..7
    for (int n = 0; n < 6; n++) begin
      for (int m = 0; m < 8; m++) begin
        run_case(n, m, ((n + m) % 3 == 0) ? 16'hFFFC : 16'(16'h0100 + n * 16 + m),
                 m[0], n[0]);
      end
    end

    // R5 upper pointer bytes not writable
    wr(3'd6, 8'h01);
    wr(3'd2, 8'h12);
    wr(3'd3, 8'h34);
    wr(3'd0, 8'hAA);
    wr(3'd1, 8'h55);
    wr(3'd6, 8'h02);
    rd_ptr(p); check("R5 pointer", p, {RSTP[31:16], 16'h1234});

    // R3 R4 status merging
    run_case(1, 1, 16'h0040, 1'b1, 1'b0);
    wr(3'd6, 8'h34);
    rd(3'd6, s); check("R3 masked merge", 32'(s), 32'h80);
    check("R3 irq off", 32'(irq), 32'h0);
    wr(3'd6, 8'h48);
    rd(3'd6, s); check("R3 ie dir copy", 32'(s), 32'hC8);
    check("R8 irq on", 32'(irq), 32'h1);
    wr(3'd6, 8'h80);
    rd(3'd6, s); check("R4 flag clear", 32'(s), 32'h00);
    check("R4 irq clear", 32'(irq), 32'h0);

    // R2 reset command
    run_case(1, 1, 16'h0050, 1'b1, 1'b0);
    wr(3'd6, 8'h49);
    rd(3'd6, s); check("R2 status", 32'(s), 32'h48);
    rd_ptr(p); check("R2 pointer", p, RSTP);
    rd_cnt(c); check("R2 count", 32'(c), 32'h0);
    check("R2 irq", 32'(irq), 32'h0);

    // R10 control write blocks acceptance
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h03);
    wr(3'd6, 8'h02);
    @(negedge clk);
    dev_valid = 1'b1; dev_data = 8'h5A;
    reg_sel = 3'd6; reg_wdata = 8'h02; reg_we = 1'b1;
    #1;
    check("R10 ready low", 32'(dev_ready), 32'h0);
    check("R10 no write", 32'(mem_we), 32'h0);
    @(negedge clk);
    reg_we = 1'b0; dev_valid = 1'b0;
    rd_cnt(c); check("R10 count intact", 32'(c), 32'h3);

    // R11 unused select
    wr(3'd7, 8'hFF);
    rd(3'd7, s); check("R11 reads zero", 32'(s), 32'h0);
    rd(3'd6, s); check("R11 status intact", 32'(s), 32'h02);
    rd_cnt(c); check("R11 count intact", 32'(c), 32'h3);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule